// File: doc/BRIEF.md
# Byte-Handshaked I2C Master Engine

This block is a single-master I2C engine that software steers through six byte-wide registers. Software places a target byte (7-bit address in bits 7:1, direction in bit 0, 1 = read) in the target register. It then writes the control register with the interface-enable and start bits. The engine produces a START condition and shifts out the target byte. After that it stops with SCL held low and waits for software at every byte boundary.

Each byte is handed over through status flags that software clears by writing 0. On a write, software loads the data port and then clears the data-empty flag, and the engine sends the byte. On a read, clearing the data-received flag makes the engine fetch one byte. A force-stop bit in the control register ends the transfer: on a write the engine issues STOP while it waits, and on a read it NACKs the next byte and then issues STOP.

Bit timing comes from an external quarter-bit strobe `qtick`, one bit per four strobes. The clock configuration register is passed straight out to the block that generates that strobe. A pin-override mode lets software toggle SCL and SDA directly, for example to free a stuck bus. While the line is released high in the high quarter of a bit, the quarter count waits for SCL to read back high.

Top module: `i2c_byte_master`

Register map (word index on `reg_addr`): 0 control, 1 status, 2 interrupt enable, 3 clock configuration, 4 target, 5 data port. Control bits: 7 non-FIFO mode (stored only), 6 forced SCL level, 5 forced SDA level, 4 pin override, 3 interface enable, 2 stored only, 1 force stop, 0 start enable. Status bits: 6 NACK seen, 5 arbitration lost (always 0), 4 stop done, 3 data empty, 2 data sent, 1 data received, 0 address done.

## Requirements
- R1: After reset every register reads 0, `scl_oe` and `sda_oe` are 0 and `irq` is 0.
- R2: An output enable of 1 pulls its line low and 0 releases it. While control bit 4 is set, `scl_oe` equals the inverse of control bit 6 and `sda_oe` equals the inverse of control bit 5. A read of the control register returns `sda_in` in bit 5.
- R3: A control write with bits 3 and 0 both set, while idle, produces a START and then sends the target register byte MSB first.
- R4: When the target acknowledges the address, status bit 0 is set together with bit 3 (write) or bit 1 (read), and SCL is held low.
- R5: A missing acknowledge on the address sets status bit 6 (with bit 0 and the direction flag) and is followed by a STOP that sets status bit 4. Status then reads 0x59 for a write address.
- R6: In a write, after the data port (index 5) is loaded and status bit 3 is cleared, the byte is sent. When it is acknowledged, bits 3 and 2 are set.
- R7: In a write, a set force-stop bit (control bit 1) while the engine waits issues a STOP. Status bit 4 is set once the STOP is complete, with both lines released.
- R8: In a read, clearing status bit 1 receives one byte, which can then be read at index 5, and sets bit 1 again. The byte is acknowledged unless force stop was set when it began; in that case it is NACKed and a STOP follows.
- R9: A status write clears the bits written as 0 and leaves the bits written as 1 unchanged.
- R10: A control write of 0 returns the engine to idle at once. Both lines are released, and the status register is not changed.
- R11: `irq` is high when any status bit is set whose bit in the enable register (index 2) is also set.
- R12: The clock configuration register drives `div_cfg`. One bus bit lasts four `qtick` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| qtick | input | 1 | Quarter-bit strobe from the clock block |
| div_cfg | output | 8 | Clock configuration for the clock block |
| irq | output | 1 | Level interrupt |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench connects the engine to a behavioural target on the wired bus. Writes of one, two and three bytes check that the target logs each byte in order and that force stop is honoured only after the last data-empty event. Reads of one to three bytes check that every byte except the last gets an ACK and the last gets a NACK, which separates the force-stop timing from the plain receive path. An address that does not match, all four forced pin combinations and a start aborted in the middle separate the NACK, override and abort paths from normal traffic.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       qtick,
  output logic [7:0] div_cfg,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  typedef enum logic [2:0] {S_IDLE, S_STA, S_BIT, S_ACK, S_HOLD, S_STO} phase_t;

  phase_t     fsm;
  logic [7:0] ctrl, div_q, tgt, txd, rxd, sh;
  logic [6:0] st, ien, set_v;
  logic [1:0] q;
  logic [2:0] bc;
  logic       adr_ph, dir, rxm, last, tx_pend, ack_ok;
  logic       scl_lo, sda_lo;

  wire wr_ctrl = reg_we && reg_addr == 3'd0;
  wire wr_st   = reg_we && reg_addr == 3'd1;
  wire abort   = wr_ctrl && reg_wdata == 8'd0;
  wire adv     = qtick && !(q == 2'd1 && !scl_in);
  wire q_end   = adv && q == 2'd3;

  always_comb begin
    set_v = '0;
    if (fsm == S_ACK && q_end) begin
      if (adr_ph) begin
        set_v[0] = 1'b1;
        if (dir) set_v[1] = 1'b1; else set_v[3] = 1'b1;
        set_v[6] = !ack_ok;
      end else if (rxm) begin
        set_v[1] = 1'b1;
      end else if (ack_ok) begin
        set_v[3] = 1'b1;
        set_v[2] = 1'b1;
      end else begin
        set_v[6] = 1'b1;
      end
    end
    if (fsm == S_STO && q_end) set_v[4] = 1'b1;
    if (abort) set_v = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm <= S_IDLE; ctrl <= '0; div_q <= '0; tgt <= '0; txd <= '0; rxd <= '0;
      sh <= '0; st <= '0; ien <= '0; q <= '0; bc <= '0; adr_ph <= 1'b0;
      dir <= 1'b0; rxm <= 1'b0; last <= 1'b0; tx_pend <= 1'b0; ack_ok <= 1'b0;
    end else begin
      st <= (wr_st ? (st & reg_wdata[6:0]) : st) | set_v;
      if (abort) begin
        fsm <= S_IDLE;
        q   <= '0;
      end else begin
        case (fsm)
          S_IDLE: if (wr_ctrl && reg_wdata[3] && reg_wdata[0]) begin
            fsm <= S_STA; q <= '0; bc <= '0; sh <= tgt;
            dir <= tgt[0]; adr_ph <= 1'b1; rxm <= 1'b0; last <= 1'b0;
          end
          S_STA: if (adv) begin
            q <= q + 2'd1;
            if (q == 2'd3) fsm <= S_BIT;
          end
          S_BIT: if (adv) begin
            q <= q + 2'd1;
            if (q == 2'd1 && rxm) sh <= {sh[6:0], sda_in};
            if (q == 2'd3) begin
              if (!rxm) sh <= {sh[6:0], 1'b0};
              bc <= bc + 3'd1;
              if (bc == 3'd7) fsm <= S_ACK;
            end
          end
          S_ACK: if (adv) begin
            q <= q + 2'd1;
            if (q == 2'd1 && !rxm) ack_ok <= !sda_in;
            if (q == 2'd3) begin
              if (adr_ph) begin
                adr_ph <= 1'b0;
                fsm    <= ack_ok ? S_HOLD : S_STO;
              end else if (rxm) begin
                rxd <= sh;
                fsm <= last ? S_STO : S_HOLD;
              end else begin
                fsm <= ack_ok ? S_HOLD : S_STO;
              end
            end
          end
          S_HOLD: begin
            q <= '0;
            if (dir) begin
              if (!st[1]) begin
                fsm <= S_BIT; rxm <= 1'b1; last <= ctrl[1]; bc <= '0;
              end
            end else if (ctrl[1]) begin
              fsm <= S_STO;
            end else if (!st[3] && tx_pend) begin
              fsm <= S_BIT; rxm <= 1'b0; sh <= txd; tx_pend <= 1'b0; bc <= '0;
            end
          end
          S_STO: if (adv) begin
            q <= q + 2'd1;
            if (q == 2'd3) fsm <= S_IDLE;
          end
          default: fsm <= S_IDLE;
        endcase
      end
      if (wr_ctrl) ctrl <= reg_wdata;
      if (reg_we && reg_addr == 3'd2) ien <= reg_wdata[6:0];
      if (reg_we && reg_addr == 3'd3) div_q <= reg_wdata;
      if (reg_we && reg_addr == 3'd4) tgt <= reg_wdata;
      if (reg_we && reg_addr == 3'd5) begin
        txd     <= reg_wdata;
        tx_pend <= 1'b1;
      end
    end
  end

  always_comb begin
    scl_lo = 1'b0;
    sda_lo = 1'b0;
    case (fsm)
      S_STA:  begin scl_lo = q == 2'd3; sda_lo = q != 2'd0; end
      S_BIT:  begin scl_lo = q == 2'd0 || q == 2'd3; sda_lo = !rxm && !sh[7]; end
      S_ACK:  begin scl_lo = q == 2'd0 || q == 2'd3; sda_lo = rxm && !last; end
      S_HOLD: scl_lo = 1'b1;
      S_STO:  begin scl_lo = q == 2'd0; sda_lo = q != 2'd3; end
      default: ;
    endcase
  end

  assign scl_oe  = ctrl[4] ? !ctrl[6] : scl_lo;
  assign sda_oe  = ctrl[4] ? !ctrl[5] : sda_lo;
  assign div_cfg = div_q;
  assign irq     = |(st & ien);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {ctrl[7:6], sda_in, ctrl[4:0]};
      3'd1:    reg_rdata = {1'b0, st};
      3'd2:    reg_rdata = {1'b0, ien};
      3'd3:    reg_rdata = div_q;
      3'd4:    reg_rdata = tgt;
      3'd5:    reg_rdata = rxd;
      default: reg_rdata = 8'd0;
    endcase
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [7:0] div_cfg,
  input logic [6:0] st,
  input logic       ovr
);
  AST_OVERRIDE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[4]) |=> (scl_oe == !$past(reg_wdata[6]) && sda_oe == !$past(reg_wdata[5]))); // R2
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata == 8'd0) |=> (!scl_oe && !sda_oe)); // R10
  AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1) |=> ((st & $past(st & reg_wdata[6:0])) == $past(st & reg_wdata[6:0]))); // R9
  AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd3) |=> $stable(div_cfg)); // R12
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st[4]) && !ovr) |-> (!scl_oe && !sda_oe)); // R7
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .div_cfg(div_cfg), .st(st), .ovr(ctrl[4])
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, div_cfg;
  logic irq, scl_oe, sda_oe, qtick;
  logic [1:0] qcnt = '0;
  int n_tests = 0, n_fail = 0, cyc = 0;

  logic s_pull = 1'b0, pscl = 1'b1, psda = 1'b1;
  int s_bit = -1, s_k = 0, s_nlog = 0, s_nread = 0, s_stops = 0;
  logic [7:0] s_byte = '0, s_txb = '0, s_addrbyte = '0;
  logic s_isaddr = 1'b0, s_send = 1'b0, s_mack = 1'b0;
  logic [7:0] s_log [32];
  logic s_macklog [32];
  int last_rise = 0, rise_period = 0;

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_pull);

  always #2.5 clk = ~clk;
  assign qtick = (qcnt == 2'd3);
  always @(posedge clk) begin qcnt <= qcnt + 2'd1; cyc <= cyc + 1; end

  i2c_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .qtick(qtick), .div_cfg(div_cfg), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] fk(int k);
    return 8'hA5 ^ 8'(k * 37);
  endfunction
  function automatic logic fk7(int k);
    logic [7:0] v;
    v = fk(k);
    return v[7];
  endfunction

  always @(posedge clk) begin
    pscl <= scl_line;
    psda <= sda_line;
    if (!pscl && scl_line) begin
      rise_period <= cyc - last_rise;
      last_rise   <= cyc;
    end
    if (pscl && scl_line && psda && !sda_line) begin
      s_bit <= -1; s_isaddr <= 1'b1; s_pull <= 1'b0; s_send <= 1'b0; s_k <= 0;
    end else if (pscl && scl_line && !psda && sda_line) begin
      s_stops <= s_stops + 1; s_pull <= 1'b0; s_send <= 1'b0;
    end else if (!pscl && scl_line) begin
      if (s_bit >= 0 && s_bit < 8) s_byte <= {s_byte[6:0], sda_line};
      else if (s_bit == 8) s_mack <= !sda_line;
    end else if (pscl && !scl_line) begin
      if (s_bit < 0) s_bit <= 0;
      else if (s_bit < 7) begin
        s_bit <= s_bit + 1;
        if (s_send) s_pull <= !s_txb[6 - s_bit];
      end else if (s_bit == 7) begin
        s_bit <= 8;
        if (s_send) s_pull <= 1'b0;
        else if (s_isaddr) s_pull <= (s_byte[7:1] == SLV);
        else s_pull <= 1'b1;
      end else begin
        s_bit <= 0;
        if (s_isaddr) begin
          s_isaddr <= 1'b0;
          s_addrbyte <= s_byte;
          if (s_byte[7:1] == SLV && s_byte[0]) begin
            s_send <= 1'b1; s_txb <= fk(0); s_pull <= !fk7(0); s_k <= 1;
          end else s_pull <= 1'b0;
        end else if (s_send) begin
          s_macklog[s_nread] <= s_mack;
          s_nread <= s_nread + 1;
          if (s_mack) begin
            s_txb <= fk(s_k); s_pull <= !fk7(s_k); s_k <= s_k + 1;
          end else begin
            s_send <= 1'b0; s_pull <= 1'b0;
          end
        end else begin
          s_log[s_nlog] <= s_byte;
          s_nlog <= s_nlog + 1;
          s_pull <= 1'b0;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_st(input logic [7:0] mask, input string req);
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, v);
      if ((v & mask) == mask) return;
    end
    chk({req, " timeout"}, 32'(v), 32'(mask));
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_fail++; n_tests++;
    $display("FAIL watchdog: got %0d expected < 150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base, stops0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", {30'd0, scl_oe, sda_oe}, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    for (int a = 1; a < 6; a++) begin rd(3'(a), v); chk("R1 reg", 32'(v), 32'd0); end

    // R2: all four forced pin combinations
    for (int c = 0; c < 4; c++) begin
      wr(3'd0, 8'h90 | 8'(c[1] << 6) | 8'(c[0] << 5));
      @(negedge clk);
      chk("R2 scl", 32'(scl_oe), 32'(!c[1]));
      chk("R2 sda", 32'(sda_oe), 32'(!c[0]));
      rd(3'd0, v);
      chk("R2 sda readback", 32'(v[5]), 32'(c[0]));
    end
    wr(3'd0, 8'h00);

    // R12: clock configuration
    wr(3'd3, 8'h5A);
    @(negedge clk);
    chk("R12 div_cfg", 32'(div_cfg), 32'h5A);

    // write transfers, lengths 1..3
    for (int len = 1; len <= 3; len++) begin
      base = s_nlog; stops0 = s_stops;
      wr(3'd4, {SLV, 1'b0});
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h89);
      wait_st(8'h01, "R4 write addr");
      rd(3'd1, v); chk("R4 write addr status", 32'(v), 32'h09);
      chk("R3 address byte", 32'(s_addrbyte), 32'({SLV, 1'b0}));
      for (int i = 0; i < len; i++) begin
        wr(3'd5, 8'(8'h3C + len * 16 + i * 7));
        wr(3'd0, 8'h88);
        wr(3'd1, 8'hF7);
        wait_st(8'h08, "R6 byte ack");
        rd(3'd1, v); chk("R6 status", 32'(v & 8'h0C), 32'h0C);
      end
      wr(3'd1, 8'hF7);
      repeat (40) @(negedge clk);
      chk("R7 no stop before force", 32'(s_stops - stops0), 32'd0);
      wr(3'd0, 8'h8A);
      wait_st(8'h10, "R7 stop");
      rd(3'd1, v); chk("R7 status", 32'(v), 32'h15);
      chk("R7 stop on bus", 32'(s_stops - stops0), 32'd1);
      chk("R6 byte count", 32'(s_nlog - base), 32'(len));
      for (int i = 0; i < len; i++)
        chk("R6 byte value", 32'(s_log[base + i]), 32'(8'(8'h3C + len * 16 + i * 7)));
      if (len < 3) begin wr(3'd1, 8'h00); wr(3'd0, 8'h00); end
    end

    // R9 / R11 on status 0x15
    wr(3'd1, 8'hEF); rd(3'd1, v); chk("R9 clear stop only", 32'(v), 32'h05);
    wr(3'd1, 8'hFB); rd(3'd1, v); chk("R9 clear sent only", 32'(v), 32'h01);
    wr(3'd2, 8'h01); @(negedge clk); chk("R11 irq on", 32'(irq), 32'd1);
    wr(3'd2, 8'h10); @(negedge clk); chk("R11 irq off", 32'(irq), 32'd0);
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h00);

    // read transfers, lengths 1..3
    for (int len = 1; len <= 3; len++) begin
      base = s_nread; stops0 = s_stops;
      wr(3'd4, {SLV, 1'b1});
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h89);
      wait_st(8'h01, "R4 read addr");
      rd(3'd1, v); chk("R4 read addr status", 32'(v), 32'h03);
      chk("R3 address byte rd", 32'(s_addrbyte), 32'({SLV, 1'b1}));
      for (int i = 0; i < len; i++) begin
        wr(3'd0, (i == len - 1) ? 8'h8A : 8'h88);
        wr(3'd1, 8'hFD);
        wait_st(8'h02, "R8 byte");
        rd(3'd5, v); chk("R8 data", 32'(v), 32'(fk(i)));
      end
      wr(3'd1, 8'hFD);
      wait_st(8'h10, "R8 stop");
      rd(3'd1, v); chk("R8 final status", 32'(v), 32'h11);
      chk("R8 stop on bus", 32'(s_stops - stops0), 32'd1);
      for (int i = 0; i < len; i++)
        chk("R8 master ack", 32'(s_macklog[base + i]), 32'(i != len - 1));
      if (len == 1) chk("R12 bit period", 32'(rise_period), 32'd16);
      wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    end

    // R5: unmatched address
    stops0 = s_stops;
    wr(3'd4, 8'h22);
    wr(3'd0, 8'h89);
    wait_st(8'h10, "R5 stop");
    rd(3'd1, v); chk("R5 status", 32'(v), 32'h59);
    chk("R5 stop on bus", 32'(s_stops - stops0), 32'd1);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);

    // R10: abort in the middle of the address byte
    wr(3'd4, {SLV, 1'b0});
    wr(3'd0, 8'h89);
    repeat (40) @(negedge clk);
    wr(3'd0, 8'h00);
    chk("R10 released", {30'd0, scl_oe, sda_oe}, 32'd0);
    begin
      int busy = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (scl_oe || sda_oe) busy++; end
      chk("R10 stays idle", 32'(busy), 32'd0);
    end
    rd(3'd1, v); chk("R10 status unchanged", 32'(v), 32'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule